// File: doc/BRIEF.md
# Interrupt-capable GPIO controller on an APB slave port

This block is a general-purpose pin controller attached to an APB slave interface. Each of up to 32 pins has an output value, a direction bit and an input path through a two-flop synchronizer. Each pin can also raise an interrupt. Software changes almost all state through pairs of write-ones registers, one that sets bits and one that clears them. A zero bit in a write leaves that pin untouched, so no read-modify-write sequence is ever needed.

Each pin's interrupt is either level sensitive or edge sensitive. A polarity bit picks active-high or rising-edge detection when set, and active-low or falling-edge detection when clear. An any-edge bit overrides the polarity for edge-sensitive pins, so that both edges fire. Edge events stay latched until software clears them. Level status follows the synchronized pin. One interrupt line is the OR over all pins of status AND enable.

A loopback control bit feeds the output register into the synchronizers in place of the pads, so the input and interrupt paths can test themselves without external wiring. Pad cells and bus error responses sit outside this block.

Top module: `gpio_irq_apb`

## Requirements
- R1: After reset, all pins are inputs (`padOe`=0), `padOut`=0, and `irqOut`=0. Reads return: enable mask 0, edge mask 0, polarity all ones, any-edge mask 0, control 0.
- R2: An APB write to offset 0x00 sets the output bits where the write data is 1 and leaves the other bits unchanged. A read of 0x00 returns the synchronized input, which reflects a pad change two clock edges later.
- R3: A write to 0x04 clears the output bits where the data is 1. A read of 0x04 returns the per-pin interrupt status, bit n for pin n.
- R4: Ones written to 0x08 make those pins outputs, and ones written to 0x0C make them inputs. A read of either offset returns the direction mask (1 = output), which also drives `padOe`.
- R5: Ones written to 0x10 enable the interrupts of those pins, and ones written to 0x14 disable them. A read of either offset returns the enable mask.
- R6: Ones written to 0x18 make those pins edge sensitive, and ones written to 0x1C make them level sensitive. A read of either offset returns the mask (1 = edge).
- R7: Ones written to 0x20 select active-high/rising for those pins, and ones written to 0x24 select active-low/falling. A read of either offset returns the polarity mask.
- R8: Ones written to 0x28 turn on any-edge for those pins, and ones written to 0x2C turn it off. A read of either offset returns the any-edge mask. With any-edge on, an edge-sensitive pin fires on both edges, whatever its polarity.
- R9: An edge event stays in the status after the pin returns to its old value, until ones are written to 0x30 for that pin. A level-sensitive pin's status follows the synchronized pin, with no latching.
- R10: `irqOut` is 1 exactly when some pin has both status and enable set. A pin whose interrupt is disabled still shows its status in the 0x04 read but does not drive `irqOut`.
- R11: Control word 0x34, bit 0 = 1, selects loopback. In loopback the synchronizers sample `padOut` and ignore `padIn`. A read of 0x34 returns the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| padIn | input | NUM_PINS | Pin input values from the pads |
| padOut | output | NUM_PINS | Pin output values |
| padOe | output | NUM_PINS | Pin output enables (1 = drive) |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults, NUM_PINS = 32 and ADDR_W = 8, so that every register is a full word wide. This makes it possible to check the set/clear pairs at both ends of the word, bits 0 and 31, in the same vector. Three pins run three different edge modes side by side: rising, falling and any-edge. This shows that the per-pin configuration really stays per pin. The full-width output register also lets loopback drive the top two bits while the unrelated low pad bits toggle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word index decoded from paddr[5:2]; the order fixes the software offsets.
  typedef enum logic [3:0] {
    W_STATE   = 4'd0,
    W_IRQ     = 4'd1,
    W_DIR_OUT = 4'd2,
    W_DIR_IN  = 4'd3,
    W_EN_SET  = 4'd4,
    W_EN_CLR  = 4'd5,
    W_EDGE    = 4'd6,
    W_LEVEL   = 4'd7,
    W_POL_SET = 4'd8,
    W_POL_CLR = 4'd9,
    W_ANY_SET = 4'd10,
    W_ANY_CLR = 4'd11,
    W_IRQ_CLR = 4'd12,
    W_CTRL    = 4'd13
  } regWord_e;

  // One write strobe per writable word, control to datapath.
  typedef struct packed {
    logic setOut;
    logic clrOut;
    logic dirOut;
    logic dirIn;
    logic enSet;
    logic enClr;
    logic edgeSel;
    logic levelSel;
    logic polSet;
    logic polClr;
    logic anySet;
    logic anyClr;
    logic irqClr;
    logic ctrlWr;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output wrStrobe_t         strobe,
  output regWord_e          rdWord,
  output logic              rdHit
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = 5;

  logic       wrEn;
  logic       addrHit;
  logic [3:0] wordIdx;

  assign wordIdx = paddr[IDX_MSB:IDX_LSB];
  assign addrHit = (paddr[ADDR_W-1:IDX_MSB+1] == '0) && (paddr[IDX_LSB-1:0] == '0);
  assign wrEn    = psel && penable && pwrite;
  assign rdWord  = regWord_e'(wordIdx);
  assign rdHit   = addrHit;

  always_comb begin
    strobe = '0;
    if (wrEn && addrHit) begin
      case (wordIdx)
        W_STATE:   strobe.setOut   = 1'b1;
        W_IRQ:     strobe.clrOut   = 1'b1;
        W_DIR_OUT: strobe.dirOut   = 1'b1;
        W_DIR_IN:  strobe.dirIn    = 1'b1;
        W_EN_SET:  strobe.enSet    = 1'b1;
        W_EN_CLR:  strobe.enClr    = 1'b1;
        W_EDGE:    strobe.edgeSel  = 1'b1;
        W_LEVEL:   strobe.levelSel = 1'b1;
        W_POL_SET: strobe.polSet   = 1'b1;
        W_POL_CLR: strobe.polClr   = 1'b1;
        W_ANY_SET: strobe.anySet   = 1'b1;
        W_ANY_CLR: strobe.anyClr   = 1'b1;
        W_IRQ_CLR: strobe.irqClr   = 1'b1;
        W_CTRL:    strobe.ctrlWr   = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R2
  strobe_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |-> (psel && penable && pwrite));

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rstN,
  input  logic sampleIn,
  input  logic edgeMode,
  input  logic activeHigh,
  input  logic anyEdge,
  input  logic clrIrq,
  output logic syncVal,
  output logic irqStat
);

  logic syncA;
  logic syncB;
  logic prevVal;
  logic latchQ;
  logic rise;
  logic fall;
  logic edgeHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevVal <= 1'b0;
    end else begin
      syncA   <= sampleIn;
      syncB   <= syncA;
      prevVal <= syncB;
    end
  end

  assign rise    = syncB & ~prevVal;
  assign fall    = ~syncB & prevVal;
  assign edgeHit = anyEdge ? (rise | fall) : (activeHigh ? rise : fall);

  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= 1'b0;
    else       latchQ <= edgeMode & (edgeHit | (latchQ & ~clrIrq));
  end

  assign syncVal = syncB;
  assign irqStat = edgeMode ? latchQ : (activeHigh ? syncB : ~syncB);

  // R9
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchQ && edgeMode && !clrIrq) |=> latchQ);

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strobe,
  input  logic [DATA_W-1:0]   wdata,
  input  regWord_e            rdWord,
  input  logic                rdHit,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [DATA_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] wd;
  logic [NUM_PINS-1:0] outReg;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] enReg;
  logic [NUM_PINS-1:0] edgeReg;
  logic [NUM_PINS-1:0] polReg;
  logic [NUM_PINS-1:0] anyReg;
  logic                loopMode;
  logic [NUM_PINS-1:0] sampleSrc;
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_PINS-1:0] irqStatus;

  assign wd = wdata[NUM_PINS-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '0;
      enReg    <= '0;
      edgeReg  <= '0;
      polReg   <= '1;
      anyReg   <= '0;
      loopMode <= 1'b0;
    end else begin
      if (strobe.setOut)   outReg   <= outReg | wd;
      if (strobe.clrOut)   outReg   <= outReg & ~wd;
      if (strobe.dirOut)   dirReg   <= dirReg | wd;
      if (strobe.dirIn)    dirReg   <= dirReg & ~wd;
      if (strobe.enSet)    enReg    <= enReg | wd;
      if (strobe.enClr)    enReg    <= enReg & ~wd;
      if (strobe.edgeSel)  edgeReg  <= edgeReg | wd;
      if (strobe.levelSel) edgeReg  <= edgeReg & ~wd;
      if (strobe.polSet)   polReg   <= polReg | wd;
      if (strobe.polClr)   polReg   <= polReg & ~wd;
      if (strobe.anySet)   anyReg   <= anyReg | wd;
      if (strobe.anyClr)   anyReg   <= anyReg & ~wd;
      if (strobe.ctrlWr)   loopMode <= wdata[0];
    end
  end

  assign sampleSrc = loopMode ? outReg : padIn;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk        (clk),
      .rstN       (rstN),
      .sampleIn   (sampleSrc[p]),
      .edgeMode   (edgeReg[p]),
      .activeHigh (polReg[p]),
      .anyEdge    (anyReg[p]),
      .clrIrq     (strobe.irqClr & wd[p]),
      .syncVal    (syncIn[p]),
      .irqStat    (irqStatus[p])
    );
  end

  assign irqOut = |(irqStatus & enReg);
  assign padOut = outReg;
  assign padOe  = dirReg;

  always_comb begin
    rdata = '0;
    if (rdHit) begin
      case (rdWord)
        W_STATE:             rdata = DATA_W'(syncIn);
        W_IRQ:               rdata = DATA_W'(irqStatus);
        W_DIR_OUT, W_DIR_IN: rdata = DATA_W'(dirReg);
        W_EN_SET, W_EN_CLR:  rdata = DATA_W'(enReg);
        W_EDGE, W_LEVEL:     rdata = DATA_W'(edgeReg);
        W_POL_SET, W_POL_CLR: rdata = DATA_W'(polReg);
        W_ANY_SET, W_ANY_CLR: rdata = DATA_W'(anyReg);
        W_CTRL:              rdata = DATA_W'(loopMode);
        default:             rdata = '0;
      endcase
    end
  end

  // R2
  set_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOut |=> ((padOut & $past(wd)) == $past(wd)));

  // R3
  clr_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrOut |=> ((padOut & $past(wd)) == '0));

  // R4
  dir_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirIn |=> ((padOe & $past(wd)) == '0));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enClr && !strobe.enSet) |=> ((enReg & $past(wd)) == '0));

endmodule

// File: rtl/gpio_irq_apb.sv
module gpio_irq_apb
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [31:0]         pwdata,
  output logic [31:0]         prdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);

  localparam int DATA_W = 32;

  wrStrobe_t strobe;
  regWord_e  rdWord;
  logic      rdHit;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strobe  (strobe),
    .rdWord  (rdWord),
    .rdHit   (rdHit)
  );

  gpio_irq_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wdata  (pwdata),
    .rdWord (rdWord),
    .rdHit  (rdHit),
    .padIn  (padIn),
    .rdata  (prdata),
    .padOut (padOut),
    .padOe  (padOe),
    .irqOut (irqOut)
  );

endmodule

// File: tb/test_gpio_irq_apb.sv
module test_gpio_irq_apb;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 32;
  localparam int AW         = 8;

  typedef struct packed {
    logic [7:0]  wAddr;
    logic [31:0] wData;
    logic [7:0]  rAddr;
    logic [31:0] expVal;
    logic [3:0]  req;
  } vec_t;

  // Configuration set/clear pairs, applied in order from reset.
  localparam vec_t VECS [10] = '{
    '{8'h08, 32'h8000_00FF, 8'h0C, 32'h8000_00FF, 4'd4},
    '{8'h0C, 32'h0000_000F, 8'h08, 32'h8000_00F0, 4'd4},
    '{8'h10, 32'h0000_F00F, 8'h14, 32'h0000_F00F, 4'd5},
    '{8'h14, 32'h0000_000F, 8'h10, 32'h0000_F000, 4'd5},
    '{8'h18, 32'h00FF_0000, 8'h1C, 32'h00FF_0000, 4'd6},
    '{8'h1C, 32'h000F_0000, 8'h18, 32'h00F0_0000, 4'd6},
    '{8'h24, 32'h0000_FFFF, 8'h20, 32'hFFFF_0000, 4'd7},
    '{8'h20, 32'h0000_00FF, 8'h24, 32'hFFFF_00FF, 4'd7},
    '{8'h28, 32'h8000_0001, 8'h2C, 32'h8000_0001, 4'd8},
    '{8'h2C, 32'h0000_0001, 8'h28, 32'h8000_0000, 4'd8}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             psel = 1'b0;
  logic             penable = 1'b0;
  logic             pwrite = 1'b0;
  logic [AW-1:0]    paddr = '0;
  logic [31:0]      pwdata = '0;
  logic [31:0]      prdata;
  logic [NPINS-1:0] padIn = '0;
  logic [NPINS-1:0] padOut;
  logic [NPINS-1:0] padOe;
  logic             irqOut;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_apb #(.NUM_PINS(NPINS), .ADDR_W(AW)) i_gpio_irq_apb (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // Table of set/clear pairs (R4 R5 R6 R7 R8)
    for (int i = 0; i < 10; i++) begin
      apbWrite(VECS[i].wAddr, VECS[i].wData);
      apbRead(VECS[i].rAddr, rd);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].expVal);
    end
    chk("R4 padOe follows direction", 32'(padOe), 32'h8000_00F0);

    doReset();
    // R1 reset state
    @(negedge clk);
    chk("R1 padOe", 32'(padOe), 32'h0);
    chk("R1 padOut", 32'(padOut), 32'h0);
    chk("R1 irqOut", 32'(irqOut), 32'h0);
    apbRead(8'h10, rd); chk("R1 enable", rd, 32'h0);
    apbRead(8'h18, rd); chk("R1 edge", rd, 32'h0);
    apbRead(8'h20, rd); chk("R1 polarity", rd, 32'hFFFF_FFFF);
    apbRead(8'h28, rd); chk("R1 anyedge", rd, 32'h0);
    apbRead(8'h34, rd); chk("R1 control", rd, 32'h0);

    // R2 set with zeros untouched, R3 clear
    apbWrite(8'h00, 32'h0000_00A5);
    chk("R2 set out", 32'(padOut), 32'h0000_00A5);
    apbWrite(8'h00, 32'h8000_0F00);
    chk("R2 zeros untouched", 32'(padOut), 32'h8000_0FA5);
    apbWrite(8'h04, 32'h8000_0005);
    chk("R3 clear out", 32'(padOut), 32'h0000_0FA0);

    // R2 input sample: two edges after the pad change
    @(negedge clk);
    padIn = 32'h1234_5670;
    apbRead(8'h00, rd);
    chk("R2 sync input", rd, 32'h1234_5670);
    padIn = '0;
    settle();

    // R9 rising edge latch on pin 0, R10 irq when enabled
    apbWrite(8'h18, 32'h0000_0007);
    apbWrite(8'h24, 32'h0000_0006);
    apbWrite(8'h28, 32'h0000_0004);
    apbWrite(8'h10, 32'h0000_0001);
    padIn[0] = 1'b1;
    settle();
    padIn[0] = 1'b0;
    settle();
    apbRead(8'h04, rd);
    chk("R9 rising latched after pin returns", rd & 32'h1, 32'h1);
    chk("R10 irq with enabled status", 32'(irqOut), 32'h1);
    apbWrite(8'h30, 32'h0000_0001);
    apbRead(8'h04, rd);
    chk("R9 irq-clear word clears latch", rd & 32'h1, 32'h0);
    chk("R10 irq drops after clear", 32'(irqOut), 32'h0);

    // R7 falling polarity on pin 1
    padIn[1] = 1'b1;
    settle();
    apbRead(8'h04, rd);
    chk("R7 falling pin ignores rise", rd & 32'h2, 32'h0);
    padIn[1] = 1'b0;
    settle();
    apbRead(8'h04, rd);
    chk("R7 falling pin fires on fall", rd & 32'h2, 32'h2);

    // R8 any-edge on pin 2 (polarity falling) fires on a rise
    padIn[2] = 1'b1;
    settle();
    apbRead(8'h04, rd);
    chk("R8 any-edge fires on rise", rd & 32'h4, 32'h4);
    chk("R10 disabled pins keep irqOut low", 32'(irqOut), 32'h0);
    apbWrite(8'h30, 32'h0000_0006);
    padIn[2] = 1'b0;
    settle();
    apbRead(8'h04, rd);
    chk("R8 any-edge fires on fall", rd & 32'h4, 32'h4);
    apbWrite(8'h30, 32'h0000_0004);

    // R9 level pin 3 follows, R10 irq follows it when enabled
    apbWrite(8'h10, 32'h0000_0008);
    padIn[3] = 1'b1;
    settle();
    apbRead(8'h04, rd);
    chk("R9 level status high", rd & 32'h8, 32'h8);
    chk("R10 level irq high", 32'(irqOut), 32'h1);
    padIn[3] = 1'b0;
    settle();
    apbRead(8'h04, rd);
    chk("R9 level status not latched", rd & 32'h8, 32'h0);
    chk("R10 level irq low", 32'(irqOut), 32'h0);

    // R11 loopback: padIn ignored, padOut sampled
    apbWrite(8'h34, 32'h0000_0001);
    apbRead(8'h34, rd);
    chk("R11 control readback", rd, 32'h1);
    apbWrite(8'h00, 32'hC000_0000);
    padIn = 32'h0000_00FF;
    settle();
    apbRead(8'h00, rd);
    chk("R11 loopback samples padOut", rd, 32'hC000_0FA0);
    apbWrite(8'h34, 32'h0000_0000);
    settle();
    apbRead(8'h00, rd);
    chk("R11 normal mode samples pads", rd, 32'h0000_00FF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule